// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block gathers sixty-four interrupt request lines and presents them to a processor through three kinds of output. An IRQ line and an FIQ line each carry the OR of the enabled, pending sources that are steered to them. Six auxiliary flags do the same for the remaining destination codes. A vector register reports the number of the winning IRQ source. Every source has a private control byte that enables it, picks its trigger (active-high level, rising edge, falling edge, or both edges) and picks its destination.

Edge-triggered sources latch a pending bit that stays set until software writes a one to the matching status bit. Level-triggered sources show the live input in the status words. The vector search runs in one of two orders. In fixed order the lowest source number wins. In rotating order the search begins at the source after the one most recently read from the vector register and wraps around. A small two-state machine tracks whether any IRQ-routed request exists. In `VS_IDLE` the vector reads as 63. In `VS_HOLD` it reads the winner. Transition `T_RAISE` (VS_IDLE to VS_HOLD) fires when an enabled IRQ request appears. Transition `T_DRAIN` (VS_HOLD to VS_IDLE) fires when none remains. `T_STAY` keeps the current state. The register bus is 32 bits wide with byte enables; reads are combinational and writes commit on the clock edge.

Top module: `intc_vec64_top`

## Requirements
- R1: After reset every control byte, both priority words and every latched edge are zero, the vector reads 63, and irq_out, fiq_out and aux_out are low.
- R2: Source n has a control byte at byte address 0x40+n (lane n mod 4 of the word at 0x40+4*(n/4)) that is written with its byte enable and reads back as written; bit 3 is the enable.
- R3: Bit 5 of a control byte selects rising-edge and bit 6 selects falling-edge triggering. With both clear the source is level-sensitive and active high, and its status bit shows the live input.
- R4: An edge source sets its pending bit on the selected transition, and the bit stays set after the input returns.
- R5: Writing 1 to a status bit (bit n mod 32 of word 0x80 for n<32, word 0x84 otherwise) clears an edge source's pending bit. Writing 0 leaves it set. Such writes do not change a level source's status.
- R6: When a selected edge arrives in the same cycle as a write-one-to-clear of that source, the pending bit stays set.
- R7: Control bits 2:0 give the destination: 0 is IRQ, 1 is FIQ, and d in 2..7 is aux_out[d-2]. Each output is the OR of the enabled pending sources with that destination.
- R8: A source with bit 3 clear still shows pending status but drives no output and is never reported in the vector.
- R9: Under fixed priority (bit 6 of word 0x20 clear), bits 5:0 of word 0x00 give the lowest-numbered enabled pending IRQ source. With none pending they give 63, and bit 31 of word 0x84 tells a real source 63 apart.
- R10: Words 0x20 (IRQ) and 0x24 (FIQ) hold seven bits that read back as written. With bit 6 of word 0x20 set, the search starts at the source after the last value read from word 0x00 and wraps around.
- R11: irq_out, fiq_out, aux_out and the vector follow a change in enabled pending requests one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address (word aligned) |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| src_in | input | 64 | Interrupt source lines |
| irq_out | output | 1 | IRQ request |
| fiq_out | output | 1 | FIQ request |
| aux_out | output | 6 | Auxiliary destination flags |

## Verification
Two things can land on the same clock edge: a fresh edge on a source line and software's write-one-to-clear of that same status bit. The bench raises the source line and issues the clearing write in one cycle, then reads the status word and expects the bit to remain set. A second clearing write with no new edge must then drop it. A second coincidence is a vector read while rotation is on. That read moves the search start while the vector register is being refreshed, so the bench reads repeatedly with two pending sources and expects the reported numbers to alternate.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int CTRL_EN_BIT   = 3;
    localparam int CTRL_RISE_BIT = 5;
    localparam int CTRL_FALL_BIT = 6;
    localparam int PRIO_ROT_BIT  = 6;
    localparam int DEST_W        = 3;
    localparam int NDEST         = 1 << DEST_W;

    // word indices (byte address >> 2)
    localparam logic [5:0] W_VEC      = 6'd0;
    localparam logic [5:0] W_PRIO_IRQ = 6'd8;
    localparam logic [5:0] W_PRIO_FIQ = 6'd9;
    localparam logic [1:0] R_CTRL     = 2'b01;  // addr[7:6] for 0x40..0x7C
    localparam logic [4:0] R_STAT     = 5'b10000; // addr[7:3] for 0x80..0x84

    typedef enum logic {
        VS_IDLE = 1'b0,
        VS_HOLD = 1'b1
    } vec_state_e;
endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    input  logic       clr,
    output logic [7:0] ctrl_q,
    output logic       pend,
    output logic       live
);
    logic prev_q;
    logic latch_q;
    logic edge_mode;
    logic hit;

    assign edge_mode = ctrl_q[CTRL_RISE_BIT] | ctrl_q[CTRL_FALL_BIT];
    assign hit = (ctrl_q[CTRL_RISE_BIT] & src & ~prev_q)
               | (ctrl_q[CTRL_FALL_BIT] & ~src & prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q <= src;
            if (ctrl_we)
                ctrl_q <= ctrl_wdata;
            if (hit)
                latch_q <= 1'b1;
            else if (clr)
                latch_q <= 1'b0;
        end
    end

    assign pend = edge_mode ? latch_q : src;
    assign live = pend & ctrl_q[CTRL_EN_BIT];

    // R4
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ctrl_we) |=> pend);

    // R5
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit && edge_mode && !ctrl_we) |=> !pend);

    // R8
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CTRL_EN_BIT] |-> !live);
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = IW'(N - 1);
        for (int i = N - 1; i >= 0; i--) begin
            logic [IW-1:0] k;
            k = start + IW'(i);
            if (req[k])
                idx = k;
        end
    end

    // R9
    always_comb begin
        if (found)
            pick_hit_chk: assert (req[idx]);
    end
endmodule

// File: rtl/intc_vec_fsm.sv
module intc_vec_fsm
    import intc_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int IW   = $clog2(NSRC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_req,
    input  logic [IW-1:0] pick_idx,
    input  logic          rotate,
    input  logic          rd_vec,
    output logic [IW-1:0] start_idx,
    output logic          irq_out,
    output logic [IW-1:0] vec_out
);
    vec_state_e    state_q, state_d;
    logic [IW-1:0] vec_q;
    logic [IW-1:0] last_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VS_IDLE: if (any_req)  state_d = VS_HOLD;  // T_RAISE
            VS_HOLD: if (!any_req) state_d = VS_IDLE;  // T_DRAIN
            default: state_d = VS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VS_IDLE;
            vec_q   <= '1;
            last_q  <= '1;
        end else begin
            state_q <= state_d;
            vec_q   <= any_req ? pick_idx : '1;
            if (rd_vec && rotate && state_q == VS_HOLD)
                last_q <= vec_q;
        end
    end

    always_comb begin
        irq_out   = (state_q == VS_HOLD);
        vec_out   = irq_out ? vec_q : '1;
        start_idx = rotate ? last_q + 1'b1 : '0;
    end

    // R11
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> irq_out);

    // R11
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> (!irq_out && vec_out == '1));

    // R10
    rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && rotate && irq_out) |=>
            (!rotate || start_idx == IW'($past(vec_out) + 1'b1)));
endmodule

// File: rtl/intc_vec64_top.sv
module intc_vec64_top
    import intc_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW/8-1:0] bus_be,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] src_in,
    output logic            irq_out,
    output logic            fiq_out,
    output logic [NDEST-3:0] aux_out
);
    localparam int IW    = $clog2(NSRC);
    localparam int LANES = DW / 8;
    localparam int LW    = $clog2(LANES);
    localparam int SW    = $clog2(DW);

    logic [7:0]      ctrl   [NSRC];
    logic [NSRC*8-1:0] ctrl_flat;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] live;
    logic [NSRC-1:0] ctrl_we;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] dest_req [NDEST];
    logic [NDEST-1:0] dest_any;
    logic [NDEST-1:0] dest_q;
    logic [6:0]      prio_irq_q, prio_fiq_q;
    logic [5:0]      waddr;
    logic            wr_en, rd_en;
    logic            pick_found;
    logic [IW-1:0]   pick_idx, start_idx, vec;

    assign waddr = bus_addr[7:2];
    assign wr_en = bus_sel & bus_wr  & (bus_addr[1:0] == 2'b00);
    assign rd_en = bus_sel & ~bus_wr & (bus_addr[1:0] == 2'b00);

    for (genvar n = 0; n < NSRC; n++) begin : g_src
        assign ctrl_we[n] = wr_en && bus_addr[7:6] == R_CTRL
                          && bus_addr[5:2] == 4'(n / LANES)
                          && bus_be[n % LANES];
        assign clr[n] = wr_en && bus_addr[7:3] == R_STAT
                      && bus_addr[2] == 1'(n / DW)
                      && bus_be[(n % DW) / 8]
                      && bus_wdata[n % DW];
        assign ctrl_flat[n*8 +: 8] = ctrl[n];

        intc_src_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .src        (src_in[n]),
            .ctrl_we    (ctrl_we[n]),
            .ctrl_wdata (bus_wdata[(n % LANES)*8 +: 8]),
            .clr        (clr[n]),
            .ctrl_q     (ctrl[n]),
            .pend       (pend[n]),
            .live       (live[n])
        );

        for (genvar d = 0; d < NDEST; d++) begin : g_dst
            assign dest_req[d][n] = live[n] && ctrl[n][DEST_W-1:0] == DEST_W'(d);
        end
    end

    for (genvar d = 0; d < NDEST; d++) begin : g_any
        assign dest_any[d] = |dest_req[d];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dest_q     <= '0;
            prio_irq_q <= '0;
            prio_fiq_q <= '0;
        end else begin
            dest_q <= dest_any;
            if (wr_en && bus_be[0] && waddr == W_PRIO_IRQ)
                prio_irq_q <= bus_wdata[6:0];
            if (wr_en && bus_be[0] && waddr == W_PRIO_FIQ)
                prio_fiq_q <= bus_wdata[6:0];
        end
    end

    intc_prio_pick #(.N(NSRC), .IW(IW)) u_pick (
        .req   (dest_req[0]),
        .start (start_idx),
        .found (pick_found),
        .idx   (pick_idx)
    );

    intc_vec_fsm #(.NSRC(NSRC), .IW(IW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_req   (pick_found),
        .pick_idx  (pick_idx),
        .rotate    (prio_irq_q[PRIO_ROT_BIT]),
        .rd_vec    (rd_en && waddr == W_VEC),
        .start_idx (start_idx),
        .irq_out   (irq_out),
        .vec_out   (vec)
    );

    assign fiq_out = dest_q[1];
    assign aux_out = dest_q[NDEST-1:2];

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (waddr == W_VEC)
                bus_rdata[IW-1:0] = vec;
            else if (waddr == W_PRIO_IRQ)
                bus_rdata[6:0] = prio_irq_q;
            else if (waddr == W_PRIO_FIQ)
                bus_rdata[6:0] = prio_fiq_q;
            else if (bus_addr[7:6] == R_CTRL)
                bus_rdata = ctrl_flat[int'(bus_addr[5:2])*DW +: DW];
            else if (bus_addr[7:3] == R_STAT)
                bus_rdata = pend[int'(bus_addr[2])*DW +: DW];
        end
    end

    // R7
    fiq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_out |-> $past(dest_any[1]));

    // R7
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(dest_any[0]) || $past(!rst_n));

    // R2
    ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we[0] |=> ctrl[0] == $past(bus_wdata[7:0]));

    localparam int UNUSED_SW = SW + LW;
endmodule

// File: tb/sim_intc_vec64_top.sv
module sim_intc_vec64_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_in = '0;
    logic        irq_out, fiq_out;
    logic [5:0]  aux_out;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    intc_vec64_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_in(src_in), .irq_out(irq_out),
        .fiq_out(fiq_out), .aux_out(aux_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_be = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic set_ctrl(input int n, input logic [7:0] v);
        wr(8'h40 + 8'(n & ~3), 4'b1 << (n % 4), 32'(v) << (8 * (n % 4)));
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [5:0] exp_vec(input logic [63:0] req);
        for (int i = 0; i < 64; i++)
            if (req[i]) return 6'(i);
        return 6'd63;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        logic [63:0] srcv, enm;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, d); chk("R1 vec", d, 63);
        rd(8'h20, d); chk("R1 prio irq", d, 0);
        rd(8'h24, d); chk("R1 prio fiq", d, 0);
        rd(8'h5C, d); chk("R1 ctrl", d, 0);
        chk("R1 outs", {irq_out, fiq_out, aux_out}, 0);

        // R2 byte lane write/readback
        set_ctrl(9, 8'hA5);
        rd(8'h48, d); chk("R2 lane", d, 32'h0000A500);
        set_ctrl(9, 8'h00);

        // R9 random level patterns, fixed priority
        for (int it = 0; it < 30; it++) begin
            srcv = {$urandom, $urandom};
            enm  = {$urandom, $urandom};
            for (int w = 0; w < 16; w++) begin
                logic [31:0] v;
                for (int b = 0; b < 4; b++)
                    v[b*8 +: 8] = enm[w*4+b] ? 8'h08 : 8'h00;
                wr(8'h40 + 8'(w*4), 4'hF, v);
            end
            src_in = srcv;
            settle();
            rd(8'h00, d); chk("R9 random vec", d, 32'(exp_vec(srcv & enm)));
            chk("R7 random irq", irq_out, |(srcv & enm));
            rd(8'h80, d); rd(8'h84, d2);
            chk("R3 live level status", {d2, d}, srcv);
        end
        src_in = '0;
        for (int w = 0; w < 16; w++) wr(8'h40 + 8'(w*4), 4'hF, 0);
        settle();
        chk("R11 drained", irq_out, 0);

        // R4 rising edge latch
        set_ctrl(7, 8'h28);
        @(negedge clk); src_in[7] = 1;
        repeat (2) @(negedge clk); src_in[7] = 0;
        settle();
        rd(8'h80, d); chk("R4 rise latched", d[7], 1);
        rd(8'h00, d); chk("R9 edge vec", d, 7);
        // R5 write zero no effect, write one clears
        wr(8'h80, 4'hF, 32'h0);
        rd(8'h80, d); chk("R5 w0 no effect", d[7], 1);
        wr(8'h80, 4'hF, 32'h80);
        settle();
        rd(8'h80, d); chk("R5 w1c", d[7], 0);
        rd(8'h00, d); chk("R5 vec after clear", d, 63);

        // R6 edge and clear in same cycle
        set_ctrl(5, 8'h28);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 8'h80; bus_be = 4'hF; bus_wdata = 32'h20;
        src_in[5] = 1;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_be = 0;
        rd(8'h80, d); chk("R6 edge wins", d[5], 1);
        wr(8'h80, 4'h1, 32'h20);
        rd(8'h80, d); chk("R6 later clear", d[5], 0);
        src_in[5] = 0; set_ctrl(5, 0);

        // R3/R7 falling edge to FIQ
        src_in[40] = 1;
        set_ctrl(40, 8'h49);
        @(negedge clk); src_in[40] = 0;
        settle();
        rd(8'h84, d); chk("R3 fall latched", d[8], 1);
        chk("R7 fiq", fiq_out, 1);
        chk("R7 irq not", irq_out, 0);
        wr(8'h84, 4'h2, 32'h100);
        settle();
        chk("R7 fiq drop", fiq_out, 0);
        set_ctrl(40, 0);

        // R8 masked edge source
        set_ctrl(20, 8'h20);
        @(negedge clk); src_in[20] = 1;
        @(negedge clk); src_in[20] = 0;
        settle();
        rd(8'h80, d); chk("R8 status set", d[20], 1);
        chk("R8 no irq", irq_out, 0);
        rd(8'h00, d); chk("R8 no vec", d, 63);
        wr(8'h80, 4'h4, 32'h100000); set_ctrl(20, 0);

        // R5 level status ignores w1c
        set_ctrl(2, 8'h08); src_in[2] = 1;
        wr(8'h80, 4'hF, 32'h4);
        rd(8'h80, d); chk("R5 level kept", d[2], 1);
        src_in[2] = 0; set_ctrl(2, 0);

        // R7 aux destination
        set_ctrl(12, 8'h0C); src_in[12] = 1;
        settle();
        chk("R7 aux", aux_out, 6'b000100);
        src_in[12] = 0; set_ctrl(12, 0);

        // R9 real source 63
        set_ctrl(63, 8'h08); src_in[63] = 1;
        settle();
        rd(8'h00, d); chk("R9 vec 63", d, 63);
        rd(8'h84, d); chk("R9 bit31", d[31], 1);
        chk("R9 irq 63", irq_out, 1);
        src_in[63] = 0; set_ctrl(63, 0);

        // R10 priority words and rotation
        wr(8'h24, 4'h1, 32'h55);
        rd(8'h24, d); chk("R10 fiq word", d, 32'h55);
        set_ctrl(3, 8'h08); set_ctrl(10, 8'h08);
        src_in[3] = 1; src_in[10] = 1;
        settle();
        rd(8'h00, d); chk("R9 fixed low", d, 3);
        wr(8'h20, 4'h1, 32'h40);
        rd(8'h20, d); chk("R10 irq word", d, 32'h40);
        settle();
        rd(8'h00, d); chk("R10 rot first", d, 3);
        @(negedge clk);
        rd(8'h00, d); chk("R10 rot second", d, 10);
        @(negedge clk);
        rd(8'h00, d); chk("R10 rot wrap", d, 3);
        wr(8'h20, 4'h1, 32'h0);
        settle();
        rd(8'h00, d); chk("R10 back fixed", d, 3);
        rd(8'h00, d); chk("R10 fixed repeat", d, 3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule